// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects sixteen interrupt request lines and reduces them to a single three-bit, active-low priority level for a processor. Each source has its own trigger mode, its own enable, and its own programmable level from 1 to 7. Level 0 is reserved for "no request". The level output is the highest level among all enabled, pending sources. It is held in a register, so it changes only on a clock edge.

When the processor acknowledges an interrupt, it pulses an acknowledge strobe together with the level it is servicing. One clock later the block answers in one of two ways:

- It raises a vector-valid pulse with an eight-bit vector. The vector is a programmable four-bit base followed by the index of the winning source.
- If nothing is pending at that level, it raises an autovector pulse instead, and no vector is returned.

Configuration is done through a small write-only register port. That port sets the trigger modes, the enables, the per-source levels and the vector base. It also clears edge latches.

Top module: `irq_vector_ctl`

## Requirements
- R1: After reset every source is disabled, level-triggered and at level 0, the vector base is 0, `iplN` reads 3'b111, and `vecAck` and `autoVec` are low, whatever `irqIn` carries.
- R2: A level-triggered, enabled source is pending while its input is high. One clock after the pending set changes, `iplN` equals the bitwise inverse of the highest level among pending sources, or 3'b111 when none is pending.
- R3: A source that is disabled, or whose level is 0, never affects `iplN` and is never chosen by an acknowledge.
- R4: When several pending sources share the same level, the lowest-numbered one wins the acknowledge.
- R5: An `iackStb` pulse with level L is answered on the next clock by a one-cycle `vecAck`. The accompanying `vecData` is {base[3:0], index[3:0]} of the winning pending source at level L.
- R6: If no pending source has level L, or L is 0, the answer on the next clock is a one-cycle `autoVec` with `vecAck` low.
- R7: An edge-triggered, enabled source latches a request on a rising input edge. The request stays set after the input falls. An input held high does not re-latch once its latch is cleared.
- R8: An acknowledge that selects an edge-triggered source clears that source's latch.
- R9: Writing the clear register clears the edge latch of every source whose bit is 1.
- R10: Register map, written when `regWe` is high:
  - address 0: trigger modes, one bit per source, 1 = edge.
  - address 1: enables, one bit per source, 1 = enabled.
  - address 2: latch clear.
  - address 3: vector base in bits [3:0].
  - address 16+i: the level of source i in bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 16 | Raw interrupt request lines, active high |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address |
| regWdata | input | 16 | Register write data |
| iackStb | input | 1 | One-cycle acknowledge strobe |
| iackLevel | input | 3 | Level being acknowledged |
| iplN | output | 3 | Active-low priority level of the highest pending request |
| vecData | output | 8 | Vector returned for an acknowledge |
| vecAck | output | 1 | Vector valid, one cycle |
| autoVec | output | 1 | No source at the acknowledged level, one cycle |

## Verification
The assertions take for granted that `iackStb` is a single-cycle pulse. They also assume that `irqIn` and the register port change only between clock edges, and that the processor acknowledges a level only after sampling `iplN`. The stimulus follows these rules:

- Inputs are driven only at the falling edge.
- Each acknowledge is raised for exactly one cycle and then dropped.
- The acknowledged level is either the expected winning level or a level deliberately chosen to have no pending source.
- Register writes never coincide with an acknowledge.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NUM_SRC = 16;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int LVL_W   = 3;
  localparam int VEC_W   = 8;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = IDX_W + 1;

  // register addresses below the level window
  localparam logic [ADDR_W-2:0] A_MODE  = 'd0;
  localparam logic [ADDR_W-2:0] A_EN    = 'd1;
  localparam logic [ADDR_W-2:0] A_CLEAR = 'd2;
  localparam logic [ADDR_W-2:0] A_BASE  = 'd3;

  typedef struct packed {
    logic             wrMode;
    logic             wrEnable;
    logic             wrClear;
    logic             wrBase;
    logic             wrLevel;
    logic [IDX_W-1:0] lvlIdx;
    logic             ackTake;
    logic [LVL_W-1:0] ackLevel;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWe,
  input  logic [AW-1:0] regAddr,
  input  logic          iackStb,
  input  logic [LW-1:0] iackLevel,
  output ctlStrobe_t    ctl
);
  logic inLevelWin;
  logic [AW-2:0] lowAddr;

  assign inLevelWin = regAddr[AW-1];
  assign lowAddr    = regAddr[AW-2:0];

  always_comb begin
    ctl          = '0;
    ctl.wrMode   = regWe && !inLevelWin && (lowAddr == A_MODE);
    ctl.wrEnable = regWe && !inLevelWin && (lowAddr == A_EN);
    ctl.wrClear  = regWe && !inLevelWin && (lowAddr == A_CLEAR);
    ctl.wrBase   = regWe && !inLevelWin && (lowAddr == A_BASE);
    ctl.wrLevel  = regWe && inLevelWin;
    ctl.lvlIdx   = regAddr[IDX_W-1:0];
    ctl.ackTake  = iackStb;
    ctl.ackLevel = iackLevel;
  end

  // R10: at most one register target per write
  p_one_target_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.wrMode, ctl.wrEnable, ctl.wrClear, ctl.wrBase, ctl.wrLevel}));
endmodule

// File: rtl/irq_vec_datapath.sv
module irq_vec_datapath
  import irq_vec_pkg::*;
#(
  parameter int NS = NUM_SRC,
  parameter int LW = LVL_W,
  parameter int VW = VEC_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    ctl,
  input  logic [DW-1:0] wdata,
  input  logic [NS-1:0] irqIn,
  output logic [LW-1:0] iplN,
  output logic [VW-1:0] vecData,
  output logic          vecAck,
  output logic          autoVec
);
  localparam int IW = $clog2(NS);
  localparam int BW = VW - IW;

  logic [NS-1:0] modeReg, enReg, prevIn, edgeLat;
  logic [LW-1:0] lvlReg [NS];
  logic [BW-1:0] baseReg;
  logic [NS-1:0] lvlLive, pending, riseSet, clrMask;
  logic [LW-1:0] topLvl;
  logic          ackHit;
  logic [IW-1:0] ackIdx;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      enReg   <= '0;
      baseReg <= '0;
    end else begin
      if (ctl.wrMode)   modeReg <= wdata[NS-1:0];
      if (ctl.wrEnable) enReg   <= wdata[NS-1:0];
      if (ctl.wrBase)   baseReg <= wdata[BW-1:0];
    end
  end

  // per-source level registers
  for (genvar g = 0; g < NS; g++) begin : gLvl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        lvlReg[g] <= '0;
      else if (ctl.wrLevel && (ctl.lvlIdx == IW'(g)))
        lvlReg[g] <= wdata[LW-1:0];
    end
    assign lvlLive[g] = (lvlReg[g] != '0);
  end

  // edge latches: a new rising edge wins over a clear in the same cycle
  assign riseSet = irqIn & ~prevIn & modeReg & enReg;

  always_comb begin
    clrMask = ctl.wrClear ? wdata[NS-1:0] : '0;
    if (ctl.ackTake && ackHit)
      clrMask[ackIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn  <= '0;
      edgeLat <= '0;
    end else begin
      prevIn  <= irqIn;
      edgeLat <= (edgeLat & ~clrMask) | riseSet;
    end
  end

  assign pending = enReg & lvlLive & ((modeReg & edgeLat) | (~modeReg & irqIn));

  // highest pending level
  always_comb begin
    topLvl = '0;
    for (int i = 0; i < NS; i++)
      if (pending[i] && (lvlReg[i] > topLvl))
        topLvl = lvlReg[i];
  end

  // acknowledge search: lowest index at the requested level
  always_comb begin
    ackHit = 1'b0;
    ackIdx = '0;
    for (int i = NS - 1; i >= 0; i--)
      if (pending[i] && (lvlReg[i] == ctl.ackLevel)) begin
        ackHit = 1'b1;
        ackIdx = IW'(i);
      end
  end

  // registered outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iplN    <= '1;
      vecData <= '0;
      vecAck  <= 1'b0;
      autoVec <= 1'b0;
    end else begin
      iplN    <= ~topLvl;
      vecAck  <= ctl.ackTake && ackHit;
      autoVec <= ctl.ackTake && !ackHit;
      if (ctl.ackTake && ackHit)
        vecData <= {baseReg, ackIdx};
    end
  end

  // R5: every acknowledge gets exactly one kind of answer next cycle
  p_answer_follows_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ackTake |=> (vecAck ^ autoVec));

  // R6: no answer appears without an acknowledge before it
  p_no_unasked_answer_r6: assert property (@(posedge clk) disable iff (!rstN)
    (vecAck || autoVec) |-> $past(ctl.ackTake));

  // R5: the upper vector field carries the base in force at the acknowledge
  p_base_field_r5: assert property (@(posedge clk) disable iff (!rstN)
    vecAck |-> (vecData[VW-1 -: BW] == $past(baseReg)));

  // R3: with every source disabled the level lines go idle
  p_disabled_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enReg == '0) |=> (iplN == '1));

  // R2: a request level only appears after something was pending
  p_level_needs_pending_r2: assert property (@(posedge clk) disable iff (!rstN)
    (iplN != '1) |-> $past(|pending));
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
  import irq_vec_pkg::*;
#(
  parameter int NS = NUM_SRC,
  parameter int LW = LVL_W,
  parameter int VW = VEC_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NS-1:0] irqIn,
  input  logic          regWe,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWdata,
  input  logic          iackStb,
  input  logic [LW-1:0] iackLevel,
  output logic [LW-1:0] iplN,
  output logic [VW-1:0] vecData,
  output logic          vecAck,
  output logic          autoVec
);
  ctlStrobe_t ctl;

  irq_vec_ctrl #(.AW(AW), .LW(LW)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .iackStb(iackStb), .iackLevel(iackLevel), .ctl(ctl)
  );

  irq_vec_datapath #(.NS(NS), .LW(LW), .VW(VW), .DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wdata(regWdata), .irqIn(irqIn),
    .iplN(iplN), .vecData(vecData), .vecAck(vecAck), .autoVec(autoVec)
  );
endmodule

// File: tb/irq_vector_ctl_test.sv
module irq_vector_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NTAB = 12;
  // {irq[15:0], ackLvl[2:0], expLvl[2:0], expSpur, expIdx[3:0]}
  localparam logic [26:0] TAB [NTAB] = '{
    {16'h0001, 3'd1, 3'd1, 1'b0, 4'd0},
    {16'h0041, 3'd7, 3'd7, 1'b0, 4'd6},
    {16'h2040, 3'd7, 3'd7, 1'b0, 4'd6},
    {16'h2000, 3'd7, 3'd7, 1'b0, 4'd13},
    {16'h8000, 3'd2, 3'd2, 1'b0, 4'd15},
    {16'h8080, 3'd2, 3'd2, 1'b0, 4'd15},
    {16'h4002, 3'd2, 3'd2, 1'b0, 4'd1},
    {16'h0000, 3'd3, 3'd0, 1'b1, 4'd0},
    {16'h0018, 3'd5, 3'd5, 1'b0, 4'd4},
    {16'h0C00, 3'd5, 3'd5, 1'b0, 4'd11},
    {16'h0040, 3'd1, 3'd7, 1'b1, 4'd0},
    {16'h4080, 3'd1, 3'd1, 1'b0, 4'd7}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqIn = '0;
  logic        regWe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic        iackStb = 1'b0;
  logic [2:0]  iackLevel = '0;
  logic [2:0]  iplN;
  logic [7:0]  vecData;
  logic        vecAck, autoVec;
  int total = 0;
  int bad = 0;
  logic [3:0] base = 4'h5;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_vector_ctl uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .iackStb(iackStb), .iackLevel(iackLevel),
    .iplN(iplN), .vecData(vecData), .vecAck(vecAck), .autoVec(autoVec)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ack then check the answer; spur selects the expected kind
  task automatic ack(input logic [2:0] lvl, input bit spur, input logic [3:0] idx, input string req);
    @(negedge clk);
    iackStb = 1'b1; iackLevel = lvl;
    @(negedge clk);
    iackStb = 1'b0;
    if (spur)
      check(autoVec && !vecAck, req, {vecAck, autoVec}, 2'b01);
    else
      check(vecAck && !autoVec && vecData == {base, idx}, req, vecData, {base, idx});
    @(negedge clk);
    check(!vecAck && !autoVec, req, {vecAck, autoVec}, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    settle(3);
    rstN = 1'b1;
    settle(1);
    // R1 reset state
    check(iplN == 3'b111 && !vecAck && !autoVec, "R1", {iplN, vecAck, autoVec}, 5'b11100);
    irqIn = 16'hFFFF;
    settle(3);
    check(iplN == 3'b111, "R1", iplN, 3'b111);
    irqIn = '0;

    // R10 configuration: level of source i is (i mod 7)+1
    for (int i = 0; i < 16; i++) wr(5'(16 + i), 16'((i % 7) + 1));
    wr(5'd3, {12'h0, base});
    wr(5'd0, 16'h0000);
    wr(5'd1, 16'hFFFF);

    // R2 R4 R5 R6 table
    for (int t = 0; t < NTAB; t++) begin
      logic [26:0] e;
      e = TAB[t];
      @(negedge clk);
      irqIn = e[26:11];
      settle(2);
      check(iplN == ~e[7:5], "R2", iplN, ~e[7:5]);
      ack(e[10:8], e[4], e[3:0], e[4] ? "R6" : "R4/R5");
    end
    irqIn = '0;

    // R3 disabled source
    wr(5'd1, 16'hFFBF);
    @(negedge clk); irqIn = 16'h0040;
    settle(2);
    check(iplN == 3'b111, "R3", iplN, 3'b111);
    ack(3'd7, 1'b1, 4'd0, "R3");
    irqIn = '0;
    wr(5'd1, 16'hFFFF);

    // R3 level-zero source
    wr(5'd18, 16'd0);
    @(negedge clk); irqIn = 16'h0004;
    settle(2);
    check(iplN == 3'b111, "R3", iplN, 3'b111);
    irqIn = '0;
    wr(5'd18, 16'd3);

    // R5 new base
    base = 4'hA;
    wr(5'd3, {12'h0, base});
    @(negedge clk); irqIn = 16'h0001;
    settle(2);
    ack(3'd1, 1'b0, 4'd0, "R5");
    irqIn = '0;

    // R7 edge latch (source 5, level 6)
    wr(5'd0, 16'h0020);
    @(negedge clk); irqIn = 16'h0020;
    @(negedge clk); irqIn = '0;
    settle(3);
    check(iplN == 3'b001, "R7", iplN, 3'b001);

    // R8 acknowledge clears it
    ack(3'd6, 1'b0, 4'd5, "R8");
    settle(1);
    check(iplN == 3'b111, "R8", iplN, 3'b111);

    // R7 held-high input does not re-latch
    @(negedge clk); irqIn = 16'h0020;
    settle(3);
    check(iplN == 3'b001, "R7", iplN, 3'b001);
    ack(3'd6, 1'b0, 4'd5, "R8");
    settle(3);
    check(iplN == 3'b111, "R7", iplN, 3'b111);
    irqIn = '0;

    // R9 clear register
    @(negedge clk); irqIn = 16'h0020;
    @(negedge clk); irqIn = '0;
    settle(3);
    check(iplN == 3'b001, "R9", iplN, 3'b001);
    wr(5'd2, 16'h0020);
    settle(2);
    check(iplN == 3'b111, "R9", iplN, 3'b111);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule